// File: doc/BRIEF.md
# Two-Master Shared Memory Phase Sequencer

This block produces the timing that lets a processor and a video fetch engine take turns on one static RAM inside every processor clock cycle. It runs from a master clock at four times the processor rate. It splits each processor cycle into four equal phases: processor address setup, processor transfer, video address setup and video transfer. Each master therefore gets an idle stretch for its address to settle, followed by an active stretch for the data move.

From the phase it derives several signals, all registered and all active high (any active-low polarity the memory needs is added outside the block):

- the processor clock and the inverted clock for the video side;
- the processor bus-enable;
- the address multiplexer select;
- the memory chip-enable;
- the write and output strobes;
- a one-master-clock pulse that tells the video side to capture read data.

The processor owns the memory while its clock is high. The video engine owns it while the processor clock is low. The video engine only reads.

Top module: `shared_mem_sequencer`

## Requirements
- R1: A phase counter advances once per master clock edge. `phase` reads 0 in the first cycle after reset is released and then steps 0,1,2,3,0 without a gap.
- R2: `cpu_clk` is high in phases 0 and 1 and low in phases 2 and 3. While running, `vid_clk` is its exact complement.
- R3: `cpu_be` is high in phases 0 and 1 only. It never falls before `cpu_clk` falls; both drop on the same master edge.
- R4: `addr_sel` is 0 (processor address) in phases 0 and 1 and 1 (video address) in phases 2 and 3. It changes only on entry to phase 0 or phase 2.
- R5: `mem_ce` is high only in the transfer phases 1 and 3. It is low in both setup phases.
- R6: `mem_we` is high only in phase 1, and only when `cpu_rw_n` was 0 at the master edge that entered phase 1. A low `cpu_rw_n` in any other phase has no effect on `mem_we`.
- R7: `mem_oe` is high in every phase 3. It is also high in phase 1 when `cpu_rw_n` was 1 at the edge entering phase 1.
- R8: `vid_latch` is high for exactly one master clock per processor cycle, during phase 3. Read data is captured at the master edge that ends phase 3.
- R9: `rst` is synchronous and active high. At the edge after it is sampled high, `phase` is 0 and every strobe, including both clocks and `cpu_be`, is 0.
- R10: `mem_we` and `mem_oe` are never high in a cycle in which `addr_sel` has just changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, four times the processor rate |
| rst | input | 1 | Synchronous active-high reset |
| cpu_rw_n | input | 1 | Processor read/write line, 1 = read, 0 = write |
| cpu_clk | output | 1 | Processor clock, high in phases 0 and 1 |
| vid_clk | output | 1 | Inverted clock for the video side |
| cpu_be | output | 1 | Processor bus-enable |
| addr_sel | output | 1 | Address multiplexer select, 0 = processor, 1 = video |
| mem_ce | output | 1 | Memory chip-enable, transfer phases only |
| mem_we | output | 1 | Memory write strobe, processor writes only |
| mem_oe | output | 1 | Memory output-enable |
| vid_latch | output | 1 | Video read-data capture pulse |
| phase | output | 2 | Current phase number 0..3 |

## Verification
The assertions take `rst` as a synchronous level that is sampled only at master edges. They allow `cpu_rw_n` to move at any time, because only its value at the edge entering phase 1 matters. The stimulus changes `cpu_rw_n` and `rst` only on falling master edges, so each value sampled at a rising edge is unambiguous. The stimulus covers:

- constant reads;
- constant writes;
- all sixteen per-phase read/write patterns;
- a reset applied mid-cycle.

Stray write requests in phases 0, 2 and 3 are included so that R6 is tested against them.

// File: rtl/seq_pkg.sv
package seq_pkg;

    localparam int PHASE_W = 2;

    typedef enum logic [PHASE_W-1:0] {
        PH_CPU_SETUP = 2'd0,
        PH_CPU_XFER  = 2'd1,
        PH_VID_SETUP = 2'd2,
        PH_VID_XFER  = 2'd3
    } phase_e;

    typedef struct packed {
        logic cpu_clk;
        logic vid_clk;
        logic cpu_be;
        logic addr_sel;
        logic mem_ce;
        logic mem_we;
        logic mem_oe;
        logic vid_latch;
    } strobes_t;

    localparam strobes_t STROBES_IDLE = '0;

    function automatic logic cpu_half(phase_e p);
        return (p == PH_CPU_SETUP) || (p == PH_CPU_XFER);
    endfunction

    function automatic logic is_xfer(phase_e p);
        return (p == PH_CPU_XFER) || (p == PH_VID_XFER);
    endfunction

    function automatic phase_e phase_after(phase_e p);
        logic [PHASE_W-1:0] n;
        n = p;
        n = n + 1'b1;
        return phase_e'(n);
    endfunction

    function automatic strobes_t decode_strobes(phase_e p, logic rw_n);
        strobes_t s;
        s.cpu_clk   = cpu_half(p);
        s.vid_clk   = !cpu_half(p);
        s.cpu_be    = cpu_half(p);
        s.addr_sel  = !cpu_half(p);
        s.mem_ce    = is_xfer(p);
        s.mem_we    = (p == PH_CPU_XFER) && !rw_n;
        s.mem_oe    = ((p == PH_CPU_XFER) && rw_n) || (p == PH_VID_XFER);
        s.vid_latch = (p == PH_VID_XFER);
        return s;
    endfunction

endpackage

// File: rtl/seq_phase_counter.sv
module seq_phase_counter
    import seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    output phase_e phase_q,
    output phase_e phase_d
);
    logic live_q;

    // Hold phase 0 for the first edge after reset, then count freely.
    always_comb begin
        phase_d = live_q ? phase_after(phase_q) : PH_CPU_SETUP;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_CPU_SETUP;
            live_q  <= 1'b0;
        end else begin
            phase_q <= phase_d;
            live_q  <= 1'b1;
        end
    end
endmodule

// File: rtl/seq_strobe_decode.sv
module seq_strobe_decode
    import seq_pkg::*;
(
    input  phase_e   ph,
    input  logic     rw_n,
    output strobes_t strobes
);
    always_comb begin
        strobes = decode_strobes(ph, rw_n);
    end
endmodule

// File: rtl/seq_strobe_regs.sv
module seq_strobe_regs
    import seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  strobes_t d,
    output strobes_t q
);
    always_ff @(posedge clk) begin
        if (rst) q <= STROBES_IDLE;
        else     q <= d;
    end
endmodule

// File: rtl/shared_mem_sequencer.sv
module shared_mem_sequencer
    import seq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cpu_rw_n,
    output logic                 cpu_clk,
    output logic                 vid_clk,
    output logic                 cpu_be,
    output logic                 addr_sel,
    output logic                 mem_ce,
    output logic                 mem_we,
    output logic                 mem_oe,
    output logic                 vid_latch,
    output logic [PHASE_W-1:0]   phase
);
    phase_e   phase_q;
    phase_e   phase_d;
    strobes_t strobes_d;
    strobes_t strobes_q;

    seq_phase_counter u_cnt (
        .clk     (clk),
        .rst     (rst),
        .phase_q (phase_q),
        .phase_d (phase_d)
    );

    // Decode from the next phase so strobes register on the same edge as the count.
    seq_strobe_decode u_dec (
        .ph      (phase_d),
        .rw_n    (cpu_rw_n),
        .strobes (strobes_d)
    );

    seq_strobe_regs u_regs (
        .clk (clk),
        .rst (rst),
        .d   (strobes_d),
        .q   (strobes_q)
    );

    assign cpu_clk   = strobes_q.cpu_clk;
    assign vid_clk   = strobes_q.vid_clk;
    assign cpu_be    = strobes_q.cpu_be;
    assign addr_sel  = strobes_q.addr_sel;
    assign mem_ce    = strobes_q.mem_ce;
    assign mem_we    = strobes_q.mem_we;
    assign mem_oe    = strobes_q.mem_oe;
    assign vid_latch = strobes_q.vid_latch;
    assign phase     = phase_q;
endmodule

// File: rtl/seq_checker.sv
module seq_checker (
    input logic       clk,
    input logic       rst,
    input logic       cpu_rw_n,
    input logic       cpu_clk,
    input logic       vid_clk,
    input logic       cpu_be,
    input logic       addr_sel,
    input logic       mem_ce,
    input logic       mem_we,
    input logic       mem_oe,
    input logic       vid_latch,
    input logic [1:0] phase
);
    // R1
    phase_step_chk: assert property (@(posedge clk) disable iff (rst)
        (phase != 2'd0) |-> (phase == 2'($past(phase) + 2'd1)));

    // R2
    clk_complement_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cpu_clk) |-> vid_clk);

    // R3
    be_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cpu_be) |-> $fell(cpu_clk));

    // R4
    sel_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(addr_sel) |-> !mem_ce);

    // R5
    ce_alternate_chk: assert property (@(posedge clk) disable iff (rst)
        mem_ce |=> !mem_ce);

    // R6
    we_source_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (cpu_clk && !addr_sel && !$past(cpu_rw_n) && $past(cpu_be)));

    // R7
    cpu_oe_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_oe && cpu_clk) |-> $past(cpu_rw_n));

    // R8
    latch_window_chk: assert property (@(posedge clk) disable iff (rst)
        vid_latch |-> (vid_clk && mem_oe && mem_ce));

    // R9
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (!cpu_clk && !vid_clk && !cpu_be && !mem_ce && !mem_we && phase == 2'd0));

    // R10
    strobe_sel_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_we || mem_oe) |-> $stable(addr_sel));
endmodule

bind shared_mem_sequencer seq_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .cpu_rw_n  (cpu_rw_n),
    .cpu_clk   (cpu_clk),
    .vid_clk   (vid_clk),
    .cpu_be    (cpu_be),
    .addr_sel  (addr_sel),
    .mem_ce    (mem_ce),
    .mem_we    (mem_we),
    .mem_oe    (mem_oe),
    .vid_latch (vid_latch),
    .phase     (phase)
);

// File: tb/sim_shared_mem_sequencer.sv
module sim_shared_mem_sequencer;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cpu_rw_n = 1'b1;
    logic       cpu_clk, vid_clk, cpu_be, addr_sel;
    logic       mem_ce, mem_we, mem_oe, vid_latch;
    logic [1:0] phase;

    int  checks = 0;
    int  failures = 0;
    bit  done = 0;
    bit  m_live = 0;
    int  m_phase = 0;
    bit  m_rw = 1;
    bit  prev_sel = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    shared_mem_sequencer u0 (
        .clk(clk), .rst(rst), .cpu_rw_n(cpu_rw_n),
        .cpu_clk(cpu_clk), .vid_clk(vid_clk), .cpu_be(cpu_be),
        .addr_sel(addr_sel), .mem_ce(mem_ce), .mem_we(mem_we),
        .mem_oe(mem_oe), .vid_latch(vid_latch), .phase(phase)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d model_phase=%0d t=%0t",
                     tag, act, exp, m_phase, $time);
        end
    endtask

    task automatic check_outputs();
        int p;
        p = m_phase;
        if (!m_live) begin
            // R9: reset holds everything idle
            chk("R9 phase", phase, 0);
            chk("R9 strobes", {cpu_clk, vid_clk, cpu_be, addr_sel, mem_ce, mem_we, mem_oe, vid_latch}, 0);
        end else begin
            chk("R1 phase", phase, p);
            chk("R2 cpu_clk", cpu_clk, (p < 2) ? 1 : 0);
            chk("R2 vid_clk", vid_clk, (p >= 2) ? 1 : 0);
            chk("R3 cpu_be", cpu_be, (p < 2) ? 1 : 0);
            chk("R4 addr_sel", addr_sel, (p >= 2) ? 1 : 0);
            chk("R5 mem_ce", mem_ce, (p % 2 == 1) ? 1 : 0);
            chk("R6 mem_we", mem_we, (p == 1 && !m_rw) ? 1 : 0);
            chk("R7 mem_oe", mem_oe, ((p == 1 && m_rw) || p == 3) ? 1 : 0);
            chk("R8 vid_latch", vid_latch, (p == 3) ? 1 : 0);
            // R10: no strobe while the select has just moved
            chk("R10 strobe_vs_sel", ((addr_sel != prev_sel) && (mem_we || mem_oe)) ? 1 : 0, 0);
        end
        prev_sel = addr_sel;
    endtask

    // Drive at a falling edge, let one rising edge pass, check at the next falling edge.
    task automatic step(input bit rw, input bit r);
        cpu_rw_n = rw;
        rst = r;
        @(posedge clk);
        if (r) begin
            m_live = 0;
            m_phase = 0;
        end else if (!m_live) begin
            m_live = 1;
            m_phase = 0;
        end else begin
            m_phase = (m_phase + 1) % 4;
        end
        m_rw = rw;
        @(negedge clk);
        check_outputs();
    endtask

    initial begin
        @(negedge clk);
        // R9: hold reset for a few cycles
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1);
        // R1..R8: constant reads
        for (int i = 0; i < 16; i++) step(1'b1, 1'b0);
        // R6: constant writes; only phase 1 may strobe
        for (int i = 0; i < 16; i++) step(1'b0, 1'b0);
        // R6, R7: every per-phase read/write pattern
        for (int mask = 0; mask < 16; mask++) begin
            for (int k = 0; k < 8; k++) step(mask[(m_phase + 1) % 4], 1'b0);
        end
        // R9, R1: reset mid-cycle, then restart at phase 0
        step(1'b0, 1'b0);
        step(1'b0, 1'b1);
        step(1'b0, 1'b1);
        for (int i = 0; i < 12; i++) step(i[1], 1'b0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule